// File: doc/BRIEF.md
# SMIC host transaction sequencer

This block is the host side of a byte-wide, three-register management-controller channel. Software, or a local agent, fills a request buffer through a simple write port, gives the length and pulses `start`. The sequencer then moves the request across the channel one byte at a time. Each byte needs a busy-flag handshake and a check of the status code that the controller echoes back. After that it collects the reply into a response buffer, which can be read through a combinational read port.

Every step runs under a watchdog counter. A wrong status code, a nonzero completion code or an expired step timer makes the whole transaction start again from the first request byte. After a bounded number of retries the sequencer gives up. It passes through a one-cycle dead state, flags `err` and reinitialises. While no transaction is active it keeps polling the flags register and reports on `attn` whether the controller has a message waiting.

Top module: `smic_host_seq`

## Requirements
- R1: Channel registers are selected by `bus_addr`: 0 is data, 1 is control on write and status on read, 2 is flags. Control codes are 0x40 get-status, 0x41 write-start, 0x42 write-next, 0x43 write-end, 0x44 read-start, 0x45 read-next and 0x46 read-end. Each status code is its control code with bit 7 set, and 0xC0 means ready. Request bytes are written at offset 0 in order.
- R2: While the flags value reads with bit 0 (busy) set, the sequencer issues no write. Every command ends with a write of the last flags value with bit 0 forced to 1.
- R3: A transaction issues get-status and requires 0xC0. It then sends write-start with byte 0 and requires 0xC1. Each later byte waits for flags bit 6 (transmit ready) and uses write-end when it is the last byte and write-next otherwise. Write-next needs status 0xC2 before the next byte.
- R4: After status 0xC3 the data register must read 0. The sequencer then waits for flags bit 7 (receive ready) and issues read-start, expecting 0xC4.
- R5: During the read phase a byte is taken only with receive ready set. Status 0xC5 stores the byte and issues read-next. Status 0xC6 stores the final byte and issues read-end. A final status of 0xC0 with data 0 raises `done` for one cycle, returns `busy` low and leaves `rsp_len` equal to the byte count.
- R6: A `start` with `req_len` below 2 or above 80 raises `err` for one cycle and causes no channel write.
- R7: Response bytes beyond 80 are read and dropped. `rsp_len` stays at 80 and `rsp_trunc` is set.
- R8: Any unexpected status or nonzero completion code restarts the transaction from get-status and byte 0. The fourth consecutive failure raises `err` and returns to idle.
- R9: A step that does not complete within the timeout (`CLK_HZ/1000*TIMEOUT_MS` cycles) counts as a failure under R8. The timer reloads after each completed step.
- R10: When idle, `attn` follows flags bit 2 whenever busy reads clear. Flags bits 4 and 3 never affect `attn` or the sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_we | input | 1 | Request buffer write strobe |
| req_waddr | input | 7 | Request buffer write index |
| req_wdata | input | 8 | Request buffer write byte |
| req_len | input | 7 | Request length in bytes, sampled at start |
| start | input | 1 | Begin a transaction (idle only) |
| rsp_raddr | input | 7 | Response buffer read index |
| rsp_rdata | output | 8 | Response byte at `rsp_raddr` |
| rsp_len | output | 7 | Number of response bytes stored |
| rsp_trunc | output | 1 | Response exceeded the buffer |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on bad length or retries exhausted |
| attn | output | 1 | Controller has a message (idle polling) |
| bus_addr | output | 2 | Channel register select |
| bus_rd | output | 1 | Channel read strobe |
| bus_wr | output | 1 | Channel write strobe |
| bus_wdata | output | 8 | Channel write byte |
| bus_rdata | input | 8 | Channel read byte |

## Verification
The hardest case to reach is a step timeout that hits in the middle of a write phase and is then followed by a clean retry. It needs a controller that holds busy longer than the step timer just after write-start and then lets the late command finish while the host is already restarting. The bench controller model stretches the busy period past the timeout on a chosen command. It also injects bad status codes and nonzero completion codes a set number of times, so the retry count is steered both below the limit and just past it.

// File: rtl/smic_host_seq.sv
module smic_host_seq #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int TIMEOUT_MS = 2000,
  parameter int MAX_LEN    = 80,
  parameter int MAX_RETRY  = 3,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_we,
  input  logic [LW-1:0] req_waddr,
  input  logic [7:0]    req_wdata,
  input  logic [LW-1:0] req_len,
  input  logic          start,
  input  logic [LW-1:0] rsp_raddr,
  output logic [7:0]    rsp_rdata,
  output logic [LW-1:0] rsp_len,
  output logic          rsp_trunc,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          attn,
  output logic [1:0]    bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata
);

  localparam int TO_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int TW     = $clog2(TO_CYC + 1);
  localparam int RW     = $clog2(MAX_RETRY + 2);

  localparam int F_BSY = 0, F_ATTN = 2, F_TXR = 6, F_RXR = 7;

  localparam logic [7:0] C_GETST  = 8'h40;
  localparam logic [7:0] C_WSTART = 8'h41;
  localparam logic [7:0] C_WNEXT  = 8'h42;
  localparam logic [7:0] C_WEND   = 8'h43;
  localparam logic [7:0] C_RSTART = 8'h44;
  localparam logic [7:0] C_RNEXT  = 8'h45;
  localparam logic [7:0] C_REND   = 8'h46;
  localparam logic [7:0] S_BIT    = 8'h80;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_OPOK, S_WSTART, S_WNEXT, S_WEND,
    S_W2R, S_RSTART, S_RNEXT, S_REND, S_DEAD
  } st_t;

  typedef enum logic [2:0] {
    P_FLAGS, P_STAT, P_RDATA, P_CTRL, P_WDATA, P_SETBSY
  } ph_t;

  st_t st, nst_q, d_nst;
  ph_t ph;

  logic [7:0]    flags_q, ctrl_q, d_code;
  logic          pend_chk, pend_ctrl, pend_wr;
  logic          d_ok, d_wait, d_rd, d_chk, d_ctrl, d_wr;
  logic [TW-1:0] timer;
  logic [RW-1:0] tries;
  logic [LW-1:0] len_q, wr_pos, wr_rem, rd_pos;
  logic          done_q, err_q, attn_q, trunc_q;
  logic          active, rec, take;

  logic [7:0] req_mem [MAX_LEN];
  logic [7:0] rsp_mem [MAX_LEN];

  wire [7:0] stat = bus_rdata;

  always_comb begin
    d_ok = 1'b1; d_wait = 1'b0; d_rd = 1'b0; d_chk = 1'b0;
    d_ctrl = 1'b0; d_wr = 1'b0; d_code = C_GETST; d_nst = st;
    case (st)
      S_START: begin
        d_ctrl = 1'b1; d_code = C_GETST; d_nst = S_OPOK;
      end
      S_OPOK: begin
        if (stat != (S_BIT | C_GETST)) d_ok = 1'b0;
        else begin d_ctrl = 1'b1; d_wr = 1'b1; d_code = C_WSTART; d_nst = S_WSTART; end
      end
      S_WSTART, S_WNEXT: begin
        if (stat != (S_BIT | ((st == S_WSTART) ? C_WSTART : C_WNEXT))) d_ok = 1'b0;
        else if (!flags_q[F_TXR]) d_wait = 1'b1;
        else begin
          d_ctrl = 1'b1; d_wr = 1'b1;
          if (wr_rem == LW'(1)) begin d_code = C_WEND;  d_nst = S_WEND;  end
          else                  begin d_code = C_WNEXT; d_nst = S_WNEXT; end
        end
      end
      S_WEND: begin
        if (stat != (S_BIT | C_WEND)) d_ok = 1'b0;
        else begin d_rd = 1'b1; d_chk = 1'b1; d_nst = S_W2R; end
      end
      S_W2R: begin
        if (!flags_q[F_RXR]) d_wait = 1'b1;
        else begin d_ctrl = 1'b1; d_code = C_RSTART; d_nst = S_RSTART; end
      end
      S_RSTART: begin
        if (stat != (S_BIT | C_RSTART)) d_ok = 1'b0;
        else if (!flags_q[F_RXR]) d_wait = 1'b1;
        else begin d_rd = 1'b1; d_ctrl = 1'b1; d_code = C_RNEXT; d_nst = S_RNEXT; end
      end
      S_RNEXT: begin
        if (stat == (S_BIT | C_REND)) begin
          d_rd = 1'b1; d_ctrl = 1'b1; d_code = C_REND; d_nst = S_REND;
        end else if (stat == (S_BIT | C_RNEXT)) begin
          if (!flags_q[F_RXR]) d_wait = 1'b1;
          else begin d_rd = 1'b1; d_ctrl = 1'b1; d_code = C_RNEXT; d_nst = S_RNEXT; end
        end else d_ok = 1'b0;
      end
      S_REND: begin
        if (stat != (S_BIT | C_GETST)) d_ok = 1'b0;
        else begin d_rd = 1'b1; d_chk = 1'b1; d_nst = S_IDLE; end
      end
      default: ;
    endcase
  end

  assign active = (st != S_IDLE) && (st != S_DEAD);
  assign rec = active && ((timer == '0) ||
                          (ph == P_STAT && !d_ok) ||
                          (ph == P_RDATA && pend_chk && bus_rdata != 8'h00));
  assign take = active && !rec && ph == P_RDATA && !pend_chk && rd_pos < LW'(MAX_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nst_q <= S_IDLE; ph <= P_FLAGS;
      flags_q <= '0; ctrl_q <= '0;
      pend_chk <= 1'b0; pend_ctrl <= 1'b0; pend_wr <= 1'b0;
      timer <= TW'(TO_CYC - 1); tries <= '0;
      len_q <= '0; wr_pos <= '0; wr_rem <= '0; rd_pos <= '0;
      done_q <= 1'b0; err_q <= 1'b0; attn_q <= 1'b0; trunc_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (req_len < LW'(2) || req_len > LW'(MAX_LEN)) err_q <= 1'b1;
            else begin
              st <= S_START; ph <= P_FLAGS; tries <= '0;
              len_q <= req_len; wr_pos <= '0; wr_rem <= req_len;
              rd_pos <= '0; trunc_q <= 1'b0; timer <= TW'(TO_CYC - 1);
            end
          end else if (!bus_rdata[F_BSY]) attn_q <= bus_rdata[F_ATTN];
        end
        S_DEAD: begin
          err_q <= 1'b1;
          st <= S_IDLE;
        end
        default: begin
          if (rec) begin
            if (tries == RW'(MAX_RETRY)) st <= S_DEAD;
            else begin
              tries <= tries + 1'b1; st <= S_START;
              wr_pos <= '0; wr_rem <= len_q; rd_pos <= '0; trunc_q <= 1'b0;
            end
            ph <= P_FLAGS;
            timer <= TW'(TO_CYC - 1);
          end else begin
            timer <= timer - 1'b1;
            case (ph)
              P_FLAGS: begin
                flags_q <= bus_rdata;
                if (!bus_rdata[F_BSY]) ph <= P_STAT;
              end
              P_STAT: begin
                if (d_wait) ph <= P_FLAGS;
                else begin
                  pend_chk <= d_chk; pend_ctrl <= d_ctrl; pend_wr <= d_wr;
                  nst_q <= d_nst; ctrl_q <= d_code;
                  ph <= d_rd ? P_RDATA : P_CTRL;
                end
              end
              P_RDATA: begin
                if (!pend_chk) begin
                  if (rd_pos < LW'(MAX_LEN)) rd_pos <= rd_pos + 1'b1;
                  else trunc_q <= 1'b1;
                end
                if (pend_ctrl) ph <= P_CTRL;
                else begin
                  st <= nst_q; ph <= P_FLAGS; timer <= TW'(TO_CYC - 1);
                  if (nst_q == S_IDLE) done_q <= 1'b1;
                end
              end
              P_CTRL: ph <= pend_wr ? P_WDATA : P_SETBSY;
              P_WDATA: begin
                wr_pos <= wr_pos + 1'b1;
                wr_rem <= wr_rem - 1'b1;
                ph <= P_SETBSY;
              end
              P_SETBSY: begin
                st <= nst_q; ph <= P_FLAGS; timer <= TW'(TO_CYC - 1);
              end
              default: ph <= P_FLAGS;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (req_we && req_waddr < LW'(MAX_LEN)) req_mem[req_waddr] <= req_wdata;
    if (take) rsp_mem[rd_pos] <= bus_rdata;
  end

  assign bus_rd = (st == S_IDLE) || (active && (ph == P_FLAGS || ph == P_STAT || ph == P_RDATA));
  assign bus_wr = active && (ph == P_CTRL || ph == P_WDATA || ph == P_SETBSY);

  always_comb begin
    bus_addr  = 2'd2;
    bus_wdata = 8'h00;
    if (active) begin
      case (ph)
        P_STAT:   bus_addr = 2'd1;
        P_RDATA:  bus_addr = 2'd0;
        P_CTRL:   begin bus_addr = 2'd1; bus_wdata = ctrl_q; end
        P_WDATA:  begin bus_addr = 2'd0; bus_wdata = req_mem[wr_pos]; end
        P_SETBSY: begin bus_addr = 2'd2; bus_wdata = flags_q | 8'h01; end
        default:  bus_addr = 2'd2;
      endcase
    end
  end

  assign rsp_rdata = (rsp_raddr < LW'(MAX_LEN)) ? rsp_mem[rsp_raddr] : 8'h00;
  assign rsp_len   = rd_pos;
  assign rsp_trunc = trunc_q;
  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign err       = err_q;
  assign attn      = attn_q;

endmodule

// File: rtl/smic_host_seq_chk.sv
module smic_host_seq_chk #(
  parameter int MAX_LEN = 80,
  parameter int LW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [1:0]    bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic [LW-1:0] rsp_len,
  input logic          rsp_trunc
);

  assert_rd_wr_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_ctrl_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |-> (bus_wdata >= 8'h40 && bus_wdata <= 8'h46));

  assert_wait_on_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_rd && bus_addr == 2'd2 && bus_rdata[0]) |=> !bus_wr);

  assert_set_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |-> bus_wdata[0]);

  assert_poll_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> !bus_wr);

  assert_done_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err));

  assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_len <= LW'(MAX_LEN));

  assert_trunc_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_trunc |-> rsp_len == LW'(MAX_LEN));

  assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_wr);

endmodule

bind smic_host_seq smic_host_seq_chk #(.MAX_LEN(MAX_LEN), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rsp_len(rsp_len), .rsp_trunc(rsp_trunc)
);

// File: tb/smic_host_seq_tb.sv
module smic_host_seq_tb;

  localparam int LW = 7;
  localparam int STALL = 1200;
  localparam int NV = 10;

  // {req_len, rsp_len, fault kind, fault count, bit1 extra flag bits, bit0 expect ok}
  localparam logic [31:0] VEC [NV] = '{
    {8'd2,  8'd3,  4'd0, 4'd0, 8'h01},
    {8'd5,  8'd10, 4'd0, 4'd0, 8'h03},
    {8'd80, 8'd80, 4'd0, 4'd0, 8'h01},
    {8'd7,  8'd85, 4'd0, 4'd0, 8'h01},
    {8'd4,  8'd4,  4'd1, 4'd2, 8'h01},
    {8'd6,  8'd5,  4'd2, 4'd1, 8'h03},
    {8'd3,  8'd6,  4'd3, 4'd3, 8'h01},
    {8'd4,  8'd3,  4'd4, 4'd1, 8'h01},
    {8'd3,  8'd4,  4'd1, 4'd4, 8'h00},
    {8'd9,  8'd2,  4'd2, 4'd4, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_we = 1'b0;
  logic [LW-1:0] req_waddr = '0, req_len = '0, rsp_raddr = '0;
  logic [7:0] req_wdata = '0;
  logic start = 1'b0;
  logic [7:0] rsp_rdata, bus_wdata, bus_rdata;
  logic [LW-1:0] rsp_len;
  logic rsp_trunc, busy, done, err, attn, bus_rd, bus_wr;
  logic [1:0] bus_addr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [7:0] tb_xflags = 8'h00;
  int cfg_fault = 0, cfg_fcnt = 0, cfg_rlen = 2, cfg_seed = 0;

  logic [7:0] m_flags = 8'h00, m_status = 8'hC0, m_data = 8'h00;
  logic [7:0] m_ctrl = 8'h00, m_wbyte = 8'h00;
  logic [7:0] cap [128];
  int cap_n = 0, ridx = 0, m_busy = 0, m_gs = 0, m_fused = 0, m_wrs = 0, m_viol = 0;

  always #4 clk = ~clk;

  smic_host_seq #(.CLK_HZ(1_000_000), .TIMEOUT_MS(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_waddr(req_waddr),
    .req_wdata(req_wdata), .req_len(req_len), .start(start),
    .rsp_raddr(rsp_raddr), .rsp_rdata(rsp_rdata), .rsp_len(rsp_len),
    .rsp_trunc(rsp_trunc), .busy(busy), .done(done), .err(err), .attn(attn),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] rq(int i, int s);
    return 8'((s * 5) + (i * 3) + 1);
  endfunction

  function automatic logic [7:0] rb(int i, int s);
    return 8'((s + i * 7) ^ 8'h5A);
  endfunction

  assign bus_rdata = (bus_addr == 2'd2) ? (m_flags | tb_xflags | {7'd0, m_busy != 0}) :
                     (bus_addr == 2'd1) ? m_status : m_data;

  // controller model
  always @(posedge clk) begin
    if (start) begin
      m_gs <= 0; m_fused <= 0; m_wrs <= 0; m_viol <= 0;
    end
    if (bus_wr) begin
      m_wrs <= m_wrs + 1;
      if (m_busy != 0) m_viol <= m_viol + 1;
      case (bus_addr)
        2'd1: m_ctrl <= bus_wdata;
        2'd0: m_wbyte <= bus_wdata;
        default: if (bus_wdata[0]) begin
          if (cfg_fault == 4 && m_ctrl == 8'h41 && m_fused < cfg_fcnt) begin
            m_busy <= STALL; m_fused <= m_fused + 1;
          end else m_busy <= 3;
        end
      endcase
    end
    if (m_busy != 0) begin
      m_busy <= m_busy - 1;
      if (m_busy == 1) begin
        case (m_ctrl)
          8'h40: begin
            m_gs <= m_gs + 1; cap_n <= 0; m_flags <= 8'h40;
            if (cfg_fault == 1 && m_fused < cfg_fcnt) begin
              m_status <= 8'hC2; m_fused <= m_fused + 1;
            end else m_status <= 8'hC0;
          end
          8'h41: begin cap[0] <= m_wbyte; cap_n <= 1; m_status <= 8'hC1; end
          8'h42: begin cap[cap_n] <= m_wbyte; cap_n <= cap_n + 1; m_status <= 8'hC2; end
          8'h43: begin
            cap[cap_n] <= m_wbyte; cap_n <= cap_n + 1; m_status <= 8'hC3; m_flags <= 8'h80;
            if (cfg_fault == 2 && m_fused < cfg_fcnt) begin
              m_data <= 8'h05; m_fused <= m_fused + 1;
            end else m_data <= 8'h00;
          end
          8'h44: begin m_status <= 8'hC4; m_data <= rb(0, cfg_seed); ridx <= 1; end
          8'h45: begin
            m_data <= rb(ridx, cfg_seed);
            m_status <= (ridx == cfg_rlen - 1) ? 8'hC6 : 8'hC5;
            ridx <= ridx + 1;
          end
          8'h46: begin
            m_status <= 8'hC0; m_flags <= 8'h00;
            if (cfg_fault == 3 && m_fused < cfg_fcnt) begin
              m_data <= 8'h01; m_fused <= m_fused + 1;
            end else m_data <= 8'h00;
          end
          default: m_status <= 8'hFF;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk);
    req_len = LW'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!busy && !done && !err && !bus_wr, "R5 reset idle outputs", {busy, done, err, bus_wr}, 0);
    chk(rsp_len == 0 && !rsp_trunc && !attn, "R10 reset status outputs", int'(rsp_len), 0);

    // R10 message-available polling, ignored bits
    tb_xflags = 8'h04;
    repeat (2) @(negedge clk);
    chk(attn == 1'b1, "R10 attn follows flag bit 2", attn, 1);
    tb_xflags = 8'h05;
    repeat (2) @(negedge clk);
    chk(attn == 1'b1, "R10 attn held while busy reads set", attn, 1);
    tb_xflags = 8'h18;
    repeat (2) @(negedge clk);
    chk(attn == 1'b0, "R10 bits 4 and 3 do not raise attn", attn, 0);
    tb_xflags = 8'h00;

    // R6 length bounds
    pulse_start(1);
    chk(err == 1'b1, "R6 length 1 rejected", err, 1);
    repeat (4) @(negedge clk);
    chk(m_wrs == 0 && !busy, "R6 length 1 no channel write", m_wrs, 0);
    pulse_start(81);
    chk(err == 1'b1, "R6 length 81 rejected", err, 1);
    repeat (4) @(negedge clk);
    chk(m_wrs == 0 && !busy, "R6 length 81 no channel write", m_wrs, 0);

    for (int v = 0; v < NV; v++) begin
      int len, rl, fk, fc, bad, exp_att, exp_len;
      bit exp_ok, got_done, got_err;
      len = int'(VEC[v][31:24]);
      rl  = int'(VEC[v][23:16]);
      fk  = int'(VEC[v][15:12]);
      fc  = int'(VEC[v][11:8]);
      exp_ok = VEC[v][0];
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        req_we = 1'b1; req_waddr = LW'(i); req_wdata = rq(i, v);
      end
      @(negedge clk);
      req_we = 1'b0;
      cfg_fault = fk; cfg_fcnt = fc; cfg_rlen = rl; cfg_seed = v * 11;
      tb_xflags = VEC[v][1] ? 8'h18 : 8'h00;
      pulse_start(len);
      got_done = 1'b0; got_err = 1'b0;
      for (int t = 0; t < 20000; t++) begin
        if (done) got_done = 1'b1;
        if (err) got_err = 1'b1;
        if (got_done || got_err) break;
        @(negedge clk);
      end
      tb_xflags = 8'h00;
      chk(got_done == exp_ok && got_err == !exp_ok, $sformatf("R4 R5 R8 vector %0d outcome", v),
          got_done, exp_ok);
      exp_att = exp_ok ? fc + 1 : 4;
      chk(m_gs == exp_att, $sformatf("R8 R9 vector %0d attempts", v), m_gs, exp_att);
      chk(m_viol == 0, $sformatf("R2 vector %0d writes while busy", v), m_viol, 0);
      if (exp_ok) begin
        bad = 0;
        for (int i = 0; i < len; i++) if (cap[i] != rq(i, v)) bad++;
        chk(cap_n == len && bad == 0, $sformatf("R1 R3 vector %0d request bytes", v), bad, 0);
        exp_len = (rl > 80) ? 80 : rl;
        chk(int'(rsp_len) == exp_len, $sformatf("R5 R7 vector %0d rsp_len", v), rsp_len, exp_len);
        bad = 0;
        for (int i = 0; i < exp_len; i++) begin
          rsp_raddr = LW'(i);
          #1;
          if (rsp_rdata != rb(i, v * 11)) bad++;
        end
        chk(bad == 0, $sformatf("R5 vector %0d response bytes", v), bad, 0);
        chk(rsp_trunc == (rl > 80), $sformatf("R7 vector %0d truncation flag", v), rsp_trunc, rl > 80);
      end
      @(negedge clk);
      chk(!busy, $sformatf("R8 vector %0d back to idle", v), busy, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule